// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Controller

This block decides, at every instruction boundary that the core reports, whether a pending maskable interrupt is taken and which source wins. For each source it keeps a request flag and a priority level. It also keeps a global interrupt enable and a processor priority floor. Hardware request pulses set the flags. Software can write the levels and the floor, and can clear flags. The enable is written by flag-changing instructions, and each write is tagged with the kind of instruction that made it.

A write to the enable made by a return-from-interrupt already governs the decision taken at the same boundary. A write made by any other flag-writing instruction only takes effect from the following boundary. Once a request is accepted, the accept output and the winning index are held until the core signals that it has branched to the vector. At that point the winner's flag is dropped.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset all request flags, all levels, the floor, the enable, the accept output and the winning index are 0.
- R2: A pulse on a source's request input sets that source's flag, visible from the next cycle.
- R3: A software flag write with data 0 clears the flags selected by its strobe vector. A write with data 1 changes nothing. A hardware request on the same source in the same cycle wins over the clear, and the flag ends up 1.
- R4: A source is eligible only when its flag is 1, the effective enable is 1, and its level is strictly greater than the floor. A level of 0 is never eligible.
- R5: Among eligible sources, the one with the highest level wins. On equal levels, the lowest index wins.
- R6: Acceptance is evaluated only in a cycle with the boundary strobe high, and accept_o rises in the next cycle. While accept_o is 1, further boundaries are ignored, and accept_o and win_idx_o hold their values.
- R7: An acknowledge-complete strobe while accept_o is 1 drops accept_o and clears the winner's flag in the next cycle. An acknowledge while accept_o is 0 is ignored.
- R8: An enable write tagged as return-from-interrupt (ien_kind_i = 1) applies to a boundary in the same cycle.
- R9: An enable write tagged as any other instruction (ien_kind_i = 0) leaves a boundary in the same cycle using the old enable. The new value is used from the next cycle onward.
- R10: Level and floor writes become visible the next cycle. A boundary uses the flags, levels and floor as they were registered before its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req_i | input | NUM_SRC | Hardware request pulses, one bit per source |
| flag_wr_i | input | NUM_SRC | Software flag write strobes, one bit per source |
| flag_wdata_i | input | 1 | Data for the flag writes (only 0 has an effect) |
| lvl_wr_i | input | NUM_SRC | Level write strobes, one bit per source |
| lvl_wdata_i | input | LVL_W | Level write data |
| ipl_wr_i | input | 1 | Floor write strobe |
| ipl_wdata_i | input | LVL_W | Floor write data |
| ien_wr_i | input | 1 | Enable write strobe |
| ien_wdata_i | input | 1 | Enable write data |
| ien_kind_i | input | 1 | 1 = write made by return-from-interrupt, 0 = any other instruction |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ack_done_i | input | 1 | Acknowledge complete, control has reached the vector |
| accept_o | output | 1 | An interrupt has been accepted and is waiting for acknowledge |
| win_idx_o | output | IDX_W | Index of the accepted source |
| ien_o | output | 1 | Registered global enable |
| ipl_o | output | LVL_W | Registered processor priority floor |
| req_flags_o | output | NUM_SRC | Request flags |
| levels_o | output | NUM_SRC*LVL_W | Source levels, source i at bits [i*LVL_W +: LVL_W] |

## Verification
The bench builds the block with its defaults: four sources and 3-bit levels. With these values every level from 0 to 7 can be written, the floor can sit both below and above a given source, and two sources can share a level so that the index tie-break is exercised. Directed sequences cover the same-cycle enable timing for both instruction kinds, the hardware-set-over-clear collision, and boundaries that arrive while an acceptance is still held. A randomized phase then mixes all strobes in the same cycles.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic {
        IEN_BY_OTHER  = 1'b0,
        IEN_BY_RETURN = 1'b1
    } ien_kind_e;

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             sw_clr_i,
    input  logic             ack_clr_i,
    input  logic             lvl_we_i,
    input  logic [LVL_W-1:0] lvl_wdata_i,
    output logic             flag_o,
    output logic [LVL_W-1:0] lvl_o
);

    typedef struct packed {
        logic             flag;
        logic [LVL_W-1:0] lvl;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (lvl_we_i) begin
            slot_d.lvl = lvl_wdata_i;
        end
        // hardware set has priority over any clear
        if (set_i) begin
            slot_d.flag = 1'b1;
        end else if (sw_clr_i || ack_clr_i) begin
            slot_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign flag_o = slot_q.flag;
    assign lvl_o  = slot_q.lvl;

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int NUM_SRC = 4,
    parameter int LVL_W   = 3,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]       flags_i,
    input  logic [NUM_SRC*LVL_W-1:0] levels_i,
    input  logic [LVL_W-1:0]         floor_i,
    input  logic                     enable_i,
    output logic                     any_o,
    output logic [IDX_W-1:0]         idx_o
);

    logic [LVL_W-1:0] best;
    logic [LVL_W-1:0] cand;

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        best  = '0;
        cand  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            cand = levels_i[i*LVL_W +: LVL_W];
            // strict compare keeps the lowest index on equal levels
            if (enable_i && flags_i[i] && (cand > floor_i) && (cand > best)) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
                best  = cand;
            end
        end
    end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_accept_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int LVL_W   = 3,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_req_i,
    input  logic [NUM_SRC-1:0]       flag_wr_i,
    input  logic                     flag_wdata_i,
    input  logic [NUM_SRC-1:0]       lvl_wr_i,
    input  logic [LVL_W-1:0]         lvl_wdata_i,
    input  logic                     ipl_wr_i,
    input  logic [LVL_W-1:0]         ipl_wdata_i,
    input  logic                     ien_wr_i,
    input  logic                     ien_wdata_i,
    input  logic                     ien_kind_i,
    input  logic                     boundary_i,
    input  logic                     ack_done_i,
    output logic                     accept_o,
    output logic [IDX_W-1:0]         win_idx_o,
    output logic                     ien_o,
    output logic [LVL_W-1:0]         ipl_o,
    output logic [NUM_SRC-1:0]       req_flags_o,
    output logic [NUM_SRC*LVL_W-1:0] levels_o
);

    typedef struct packed {
        logic             ien;
        logic [LVL_W-1:0] ipl;
        logic             accept;
        logic [IDX_W-1:0] win;
    } ctrl_t;

    ctrl_t              ctrl_d, ctrl_q;
    logic               eff_en;
    logic               arb_any;
    logic [IDX_W-1:0]   arb_idx;
    logic [NUM_SRC-1:0] ack_clr;
    logic [NUM_SRC-1:0] sw_clr;

    // enable seen by this boundary: a return writes through, others wait
    assign eff_en = (ien_wr_i && (ien_kind_e'(ien_kind_i) == IEN_BY_RETURN))
                    ? ien_wdata_i : ctrl_q.ien;

    assign sw_clr = flag_wr_i & {NUM_SRC{~flag_wdata_i}};

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
            irq_src_slot #(.LVL_W(LVL_W)) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .set_i       (src_req_i[g]),
                .sw_clr_i    (sw_clr[g]),
                .ack_clr_i   (ack_clr[g]),
                .lvl_we_i    (lvl_wr_i[g]),
                .lvl_wdata_i (lvl_wdata_i),
                .flag_o      (req_flags_o[g]),
                .lvl_o       (levels_o[g*LVL_W +: LVL_W])
            );
        end
    endgenerate

    irq_prio_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
        .flags_i  (req_flags_o),
        .levels_i (levels_o),
        .floor_i  (ctrl_q.ipl),
        .enable_i (eff_en),
        .any_o    (arb_any),
        .idx_o    (arb_idx)
    );

    always_comb begin
        ctrl_d  = ctrl_q;
        ack_clr = '0;
        if (ien_wr_i) begin
            ctrl_d.ien = ien_wdata_i;
        end
        if (ipl_wr_i) begin
            ctrl_d.ipl = ipl_wdata_i;
        end
        if (ctrl_q.accept) begin
            if (ack_done_i) begin
                ctrl_d.accept = 1'b0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    ack_clr[i] = (ctrl_q.win == IDX_W'(i));
                end
            end
        end else if (boundary_i && arb_any) begin
            ctrl_d.accept = 1'b1;
            ctrl_d.win    = arb_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign accept_o  = ctrl_q.accept;
    assign win_idx_o = ctrl_q.win;
    assign ien_o     = ctrl_q.ien;
    assign ipl_o     = ctrl_q.ipl;

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int NUM_SRC = 4,
    parameter int LVL_W   = 3,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       src_req_i,
    input logic                     boundary_i,
    input logic                     ack_done_i,
    input logic                     accept_o,
    input logic [IDX_W-1:0]         win_idx_o,
    input logic [LVL_W-1:0]         ipl_o,
    input logic [NUM_SRC-1:0]       req_flags_o,
    input logic [NUM_SRC*LVL_W-1:0] levels_o
);

    logic [NUM_SRC-1:0]       flags_prev_q;
    logic [NUM_SRC*LVL_W-1:0] lvls_prev_q;
    logic [LVL_W-1:0]         ipl_prev_q;
    logic [LVL_W-1:0]         win_lvl_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_prev_q <= '0;
            lvls_prev_q  <= '0;
            ipl_prev_q   <= '0;
        end else begin
            flags_prev_q <= req_flags_o;
            lvls_prev_q  <= levels_o;
            ipl_prev_q   <= ipl_o;
        end
    end

    assign win_lvl_prev = lvls_prev_q[win_idx_o*LVL_W +: LVL_W];

    p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req_i != '0) |=> ((req_flags_o & $past(src_req_i)) == $past(src_req_i)));

    p_no_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_flags_o & ~$past(req_flags_o) & ~$past(src_req_i)) == '0));

    p_win_flagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_o) |-> flags_prev_q[win_idx_o]);

    p_win_above_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_o) |-> (win_lvl_prev > ipl_prev_q));

    p_rise_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_o) |-> $past(boundary_i));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !ack_done_i) |=> (accept_o && $stable(win_idx_o)));

    p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && ack_done_i) |=> !accept_o);

    p_ack_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && ack_done_i && !src_req_i[win_idx_o]) |=> !req_flags_o[$past(win_idx_o)]);

endmodule

bind irq_accept_ctrl irq_accept_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req_i   (src_req_i),
    .boundary_i  (boundary_i),
    .ack_done_i  (ack_done_i),
    .accept_o    (accept_o),
    .win_idx_o   (win_idx_o),
    .ipl_o       (ipl_o),
    .req_flags_o (req_flags_o),
    .levels_o    (levels_o)
);

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC    = 4;
    localparam int LVL_W      = 3;
    localparam int IDX_W      = 2;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [NUM_SRC-1:0]       src_req_i;
    logic [NUM_SRC-1:0]       flag_wr_i;
    logic                     flag_wdata_i;
    logic [NUM_SRC-1:0]       lvl_wr_i;
    logic [LVL_W-1:0]         lvl_wdata_i;
    logic                     ipl_wr_i;
    logic [LVL_W-1:0]         ipl_wdata_i;
    logic                     ien_wr_i;
    logic                     ien_wdata_i;
    logic                     ien_kind_i;
    logic                     boundary_i;
    logic                     ack_done_i;
    logic                     accept_o;
    logic [IDX_W-1:0]         win_idx_o;
    logic                     ien_o;
    logic [LVL_W-1:0]         ipl_o;
    logic [NUM_SRC-1:0]       req_flags_o;
    logic [NUM_SRC*LVL_W-1:0] levels_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    int m_flag [NUM_SRC];
    int m_lvl  [NUM_SRC];
    int m_ipl, m_ien, m_acc, m_win;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_accept_ctrl #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i), .flag_wr_i(flag_wr_i),
        .flag_wdata_i(flag_wdata_i), .lvl_wr_i(lvl_wr_i), .lvl_wdata_i(lvl_wdata_i),
        .ipl_wr_i(ipl_wr_i), .ipl_wdata_i(ipl_wdata_i), .ien_wr_i(ien_wr_i),
        .ien_wdata_i(ien_wdata_i), .ien_kind_i(ien_kind_i), .boundary_i(boundary_i),
        .ack_done_i(ack_done_i), .accept_o(accept_o), .win_idx_o(win_idx_o),
        .ien_o(ien_o), .ipl_o(ipl_o), .req_flags_o(req_flags_o), .levels_o(levels_o)
    );

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk(int'(accept_o), m_acc, "accept");
        chk(int'(win_idx_o), m_win, "win_idx");
        chk(int'(ien_o), m_ien, "ien");
        chk(int'(ipl_o), m_ipl, "ipl");
        for (int i = 0; i < NUM_SRC; i++) begin
            chk(int'(req_flags_o[i]), m_flag[i], $sformatf("flag%0d", i));
            chk(int'(levels_o[i*LVL_W +: LVL_W]), m_lvl[i], $sformatf("level%0d", i));
        end
    endtask

    task automatic clear_inputs();
        src_req_i = '0; flag_wr_i = '0; flag_wdata_i = 1'b0; lvl_wr_i = '0;
        lvl_wdata_i = '0; ipl_wr_i = 1'b0; ipl_wdata_i = '0; ien_wr_i = 1'b0;
        ien_wdata_i = 1'b0; ien_kind_i = 1'b0; boundary_i = 1'b0; ack_done_i = 1'b0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NUM_SRC; i++) begin
            m_flag[i] = 0;
            m_lvl[i]  = 0;
        end
        m_ipl = 0; m_ien = 0; m_acc = 0; m_win = 0;
    endtask

    // behavioural reference, evaluated on the inputs held before the edge
    task automatic model_step();
        int eff, nacc, nwin, clr, best;
        eff  = (ien_wr_i && ien_kind_i) ? int'(ien_wdata_i) : m_ien;
        nacc = m_acc; nwin = m_win; clr = -1;
        if (m_acc == 1) begin
            if (ack_done_i) begin
                nacc = 0;
                clr  = m_win;
            end
        end else if (boundary_i) begin
            best = 0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (m_flag[i] == 1 && eff == 1 && m_lvl[i] > m_ipl && m_lvl[i] > best) begin
                    best = m_lvl[i]; nwin = i; nacc = 1;
                end
            end
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_req_i[i]) m_flag[i] = 1;
            else if ((flag_wr_i[i] && !flag_wdata_i) || clr == i) m_flag[i] = 0;
            if (lvl_wr_i[i]) m_lvl[i] = int'(lvl_wdata_i);
        end
        if (ipl_wr_i) m_ipl = int'(ipl_wdata_i);
        if (ien_wr_i) m_ien = int'(ien_wdata_i);
        m_acc = nacc; m_win = nwin;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        check_all();
        clear_inputs();
    endtask

    task automatic set_level(input int src, input int lvl);
        lvl_wr_i[src] = 1'b1; lvl_wdata_i = LVL_W'(lvl); tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        clear_inputs();
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        check_all();
        rst_n = 1'b1;
        tick();

        // R2: request pulses set flags, nothing accepted with enable off
        cur_req = "R2";
        src_req_i = 4'b0101; tick();
        src_req_i = 4'b1010; tick();

        // R3: writing 1 has no effect, writing 0 clears, hardware set wins
        cur_req = "R3";
        flag_wr_i = 4'b1111; flag_wdata_i = 1'b1; tick();
        flag_wr_i = 4'b0010; tick();
        flag_wr_i = 4'b0100; src_req_i = 4'b0100; tick();
        src_req_i = 4'b0010; tick();

        // R10: levels and floor
        cur_req = "R10";
        set_level(0, 2); set_level(1, 5); set_level(2, 5); set_level(3, 1);
        ipl_wr_i = 1'b1; ipl_wdata_i = 3'd3; tick();

        // R4: enable off means no acceptance
        cur_req = "R4";
        boundary_i = 1'b1; tick();
        ien_wr_i = 1'b1; ien_wdata_i = 1'b1; ien_kind_i = 1'b0; tick();

        // R5: tie at level 5 between sources 1 and 2 goes to 1
        cur_req = "R5";
        boundary_i = 1'b1; tick();

        // R6: boundary while held is ignored, even with a higher request
        cur_req = "R6";
        lvl_wr_i[3] = 1'b1; lvl_wdata_i = 3'd7; src_req_i = 4'b1000; tick();
        boundary_i = 1'b1; tick();
        tick();

        // R7: acknowledge clears the winner, a stray one is ignored
        cur_req = "R7";
        ack_done_i = 1'b1; tick();
        ack_done_i = 1'b1; tick();
        boundary_i = 1'b1; tick();
        ack_done_i = 1'b1; tick();
        boundary_i = 1'b1; tick();
        ack_done_i = 1'b1; tick();

        // R4: only source 0 at level 2 remains, below the floor of 3
        cur_req = "R4";
        boundary_i = 1'b1; tick();
        set_level(0, 0);
        ipl_wr_i = 1'b1; ipl_wdata_i = 3'd0; tick();
        boundary_i = 1'b1; tick();

        // R9: other-kind clear with a boundary in the same cycle uses the old enable
        cur_req = "R9";
        src_req_i = 4'b1000; tick();
        ien_wr_i = 1'b1; ien_wdata_i = 1'b0; ien_kind_i = 1'b0; boundary_i = 1'b1; tick();
        ack_done_i = 1'b1; tick();
        src_req_i = 4'b1000; tick();
        boundary_i = 1'b1; tick();
        ien_wr_i = 1'b1; ien_wdata_i = 1'b1; ien_kind_i = 1'b0; boundary_i = 1'b1; tick();

        // R8: return-kind set with a boundary in the same cycle applies at once
        cur_req = "R8";
        ien_wr_i = 1'b1; ien_wdata_i = 1'b0; ien_kind_i = 1'b0; tick();
        ien_wr_i = 1'b1; ien_wdata_i = 1'b1; ien_kind_i = 1'b1; boundary_i = 1'b1; tick();
        ack_done_i = 1'b1; tick();
        src_req_i = 4'b1000; tick();
        ien_wr_i = 1'b1; ien_wdata_i = 1'b0; ien_kind_i = 1'b1; boundary_i = 1'b1; tick();
        tick();

        // R5: mixed random traffic
        cur_req = "R5";
        for (int n = 0; n < 3000; n++) begin
            src_req_i    = NUM_SRC'($urandom_range(0, 15) & $urandom_range(0, 15));
            flag_wr_i    = ($urandom_range(0, 7) == 0) ? NUM_SRC'($urandom_range(0, 15)) : '0;
            flag_wdata_i = 1'($urandom_range(0, 1));
            lvl_wr_i     = ($urandom_range(0, 5) == 0) ? NUM_SRC'($urandom_range(0, 15)) : '0;
            lvl_wdata_i  = LVL_W'($urandom_range(0, 7));
            ipl_wr_i     = ($urandom_range(0, 9) == 0);
            ipl_wdata_i  = LVL_W'($urandom_range(0, 5));
            ien_wr_i     = ($urandom_range(0, 5) == 0);
            ien_wdata_i  = ($urandom_range(0, 3) != 0);
            ien_kind_i   = 1'($urandom_range(0, 1));
            boundary_i   = 1'($urandom_range(0, 1));
            ack_done_i   = ($urandom_range(0, 2) == 0);
            tick();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule